// File: doc/BRIEF.md
# Cell Measurement Routing and Power Mode Controller

This block sits behind the command decoder of a battery-pack front end. It takes group write strobes that share one 3-bit code bus and turns them into enables for the analog measurement switches, the four cell-balancing switches and the on-chip regulator. It also tracks the operating mode: usual (measurement active), power-save (analog output grounded, detection switches open) or power-down (everything off until a charger appears).

The measurement path closes exactly two switches for each selection. One is in the upper tap row (`sw_a_o`) and one in the lower tap row (`sw_b_o`). Together they route one cell, or an offset reference next to that cell, to the measurement buffer. Choosing the grounded output is itself the request for power-save, and only an explicit "run" code on the multiplexer group brings the path back to usual mode. Balancing writes add to the switches already closed, so any set of cells can be bled with a few writes. A power-down command is refused while the charger-present input is high. Once in power-down, the block stays there until charger-present goes high.

All state is registered. An accepted write shows at the outputs in the cycle after the edge that sampled it. Control pins are plain level or strobe signals, with no handshake.

Top module: `meas_power_ctrl`

## Requirements
- R1: After reset, `mode_o` is power-save (2'b01), all measurement and balancing switches are open, `pd_o` is 0, `reg_en_o` is 1 and `reg_hi_o` is 0 (3.3 V). The stored cell selection is 000.
- R2: In usual mode, the stored selection closes exactly one bit of `sw_a_o` and one of `sw_b_o`. Bit k of `sw_a_o` is upper switch k and bit k of `sw_b_o` is lower switch k, with k=0 the reference tap. Cell selections (a,b) are: 000→(1,2), 001→(2,3), 010→(3,4), 011→(4,0). Offset selections are: 100→(2,2), 101→(3,3), 110→(4,4), 111→(0,0).
- R3: A multiplexer-group write of 001 sets usual mode (`mode_o`=2'b00). A write of 000, 010 or 011 sets power-save. Outside usual mode, both switch rows are all zero.
- R4: A cell-select write stores the new code without changing the mode. In power-save the switches stay open, and the stored code drives them once a multiplexer 001 write arrives.
- R5: Regulator-group codes: 000 and 011 give enable=1, high=0; 001 gives enable=0, high=0; 010 gives enable=1, high=1.
- R6: A regulator-group write of 100 while `charger_i` is low enters power-down (`mode_o`=2'b10, `pd_o`=1). It clears the balancing switches, opens the measurement switches and drives `reg_en_o` and `reg_hi_o` to 0. In power-down every group write is ignored. The cell selection is kept.
- R7: A power-down command while `charger_i` is high changes nothing.
- R8: In power-down, `charger_i` high leaves power-down on the next edge. The block comes out in power-save with `reg_en_o`=1 and `reg_hi_o`=0.
- R9: A balancing write of 000 opens all four balancing switches. A nonzero code c sets bit ((c-1) mod 4) of `bal_o` and leaves the other bits unchanged: 1,5→bit0; 2,6→bit1; 3,7→bit2; 4→bit3.
- R10: Unused codes (multiplexer 100–111, regulator 101–111) leave every output unchanged.
- R11: When an accepted power-down command shares a cycle with other group writes, power-down wins and the other writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| charger_i | input | 1 | Charger present |
| code_i | input | 3 | Payload shared by all group writes |
| wr_sel_i | input | 1 | Cell-select group write strobe |
| wr_mux_i | input | 1 | Multiplexer group write strobe |
| wr_reg_i | input | 1 | Regulator group write strobe |
| wr_bal_i | input | 1 | Balancing group write strobe |
| sw_a_o | output | 5 | Upper tap switch enables, bit k = tap k |
| sw_b_o | output | 5 | Lower tap switch enables, bit k = tap k |
| bal_o | output | 4 | Balancing switch enables, bit i = cell i+1 |
| reg_en_o | output | 1 | Regulator enable |
| reg_hi_o | output | 1 | Regulator high-voltage select |
| mode_o | output | 2 | 00 usual, 01 power-save, 10 power-down |
| pd_o | output | 1 | Power-down flag |

## Verification
The assertions watch, on every cycle, the invariants that follow from mode alone. Power-down leaves nothing closed and the regulator off. Outside usual mode both switch rows are open. Each row closes at most one switch, and the two rows always close together. Balancing writes never open a switch. Power-down entry, refusal and exit are checked against the command and the charger input. The exact tap pairs for each selection, the regulator code table, the ignored unused codes and the rule that power-down beats simultaneous writes can only be shown by the bench's scenarios, which compare every output against a reference model under directed and random stimulus.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [1:0] {
    MODE_USUAL = 2'b00,
    MODE_SAVE  = 2'b01,
    MODE_DOWN  = 2'b10
  } mode_t;

  localparam logic [2:0] MUX_GND_A = 3'b000;
  localparam logic [2:0] MUX_RUN   = 3'b001;
  localparam logic [2:0] MUX_GND_B = 3'b010;
  localparam logic [2:0] MUX_GND_C = 3'b011;

  localparam logic [2:0] REG_LOW_A = 3'b000;
  localparam logic [2:0] REG_OFF   = 3'b001;
  localparam logic [2:0] REG_HIGH  = 3'b010;
  localparam logic [2:0] REG_LOW_B = 3'b011;
  localparam logic [2:0] REG_PD    = 3'b100;

  localparam logic [2:0] BAL_CLEAR = 3'b000;
endpackage

// File: rtl/mpc_mode_fsm.sv
module mpc_mode_fsm
  import mpc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charger_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_mux_i,
  input  logic              wr_reg_i,
  output mode_t             mode_o,
  output logic              pd_go_o,
  output logic              reg_en_o,
  output logic              reg_hi_o
);
  mode_t mode_q;
  logic  en_q, hi_q;
  logic  pd_cmd;

  assign pd_cmd  = wr_reg_i && (code_i == CODE_W'(REG_PD));
  assign pd_go_o = pd_cmd && !charger_i && (mode_q != MODE_DOWN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_SAVE;
      en_q   <= 1'b1;
      hi_q   <= 1'b0;
    end else if (mode_q == MODE_DOWN) begin
      if (charger_i) begin
        mode_q <= MODE_SAVE;
        en_q   <= 1'b1;
        hi_q   <= 1'b0;
      end
    end else if (pd_go_o) begin
      mode_q <= MODE_DOWN;
      en_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      if (wr_mux_i) begin
        case (code_i)
          CODE_W'(MUX_RUN):   mode_q <= MODE_USUAL;
          CODE_W'(MUX_GND_A),
          CODE_W'(MUX_GND_B),
          CODE_W'(MUX_GND_C): mode_q <= MODE_SAVE;
          default:            mode_q <= mode_q;
        endcase
      end
      if (wr_reg_i) begin
        case (code_i)
          CODE_W'(REG_LOW_A),
          CODE_W'(REG_LOW_B): begin en_q <= 1'b1; hi_q <= 1'b0; end
          CODE_W'(REG_OFF):   begin en_q <= 1'b0; hi_q <= 1'b0; end
          CODE_W'(REG_HIGH):  begin en_q <= 1'b1; hi_q <= 1'b1; end
          default:            begin en_q <= en_q; hi_q <= hi_q; end
        endcase
      end
    end
  end

  assign mode_o   = mode_q;
  assign reg_en_o = en_q;
  assign reg_hi_o = hi_q;
endmodule

// File: rtl/mpc_path_decode.sv
module mpc_path_decode #(
  parameter int NCELL  = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              wr_sel_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              open_i,
  output logic [NCELL:0]    sw_a_o,
  output logic [NCELL:0]    sw_b_o
);
  logic [CODE_W-1:0] sel_q;
  int cell_idx, a_idx, b_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)                  sel_q <= '0;
    else if (wr_sel_i && !hold_i) sel_q <= code_i;
  end

  // lower tap is the next node down the stack; the bottom cell wraps to tap 0
  always_comb begin
    cell_idx = int'(sel_q[CODE_W-2:0]);
    b_idx    = (cell_idx == NCELL - 1) ? 0 : cell_idx + 2;
    a_idx    = sel_q[CODE_W-1] ? b_idx : cell_idx + 1;
  end

  for (genvar k = 0; k <= NCELL; k++) begin : g_tap
    assign sw_a_o[k] = !open_i && (a_idx == k);
    assign sw_b_o[k] = !open_i && (b_idx == k);
  end
endmodule

// File: rtl/mpc_balance.sv
module mpc_balance #(
  parameter int NCELL  = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              clear_i,
  input  logic              wr_bal_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NCELL-1:0]  bal_o
);
  int hit_idx;
  logic zero_code;

  always_comb begin
    zero_code = (code_i == '0);
    hit_idx   = zero_code ? -1 : (int'(code_i) - 1) % NCELL;
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                      bal_o[i] <= 1'b0;
      else if (clear_i)                bal_o[i] <= 1'b0;
      else if (wr_bal_i && !hold_i) begin
        if (zero_code)                 bal_o[i] <= 1'b0;
        else if (hit_idx == i)         bal_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/meas_power_ctrl.sv
module meas_power_ctrl
  import mpc_pkg::*;
#(
  parameter int NCELL  = 4,
  localparam int CODE_W = $clog2(NCELL) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charger_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_sel_i,
  input  logic              wr_mux_i,
  input  logic              wr_reg_i,
  input  logic              wr_bal_i,
  output logic [NCELL:0]    sw_a_o,
  output logic [NCELL:0]    sw_b_o,
  output logic [NCELL-1:0]  bal_o,
  output logic              reg_en_o,
  output logic              reg_hi_o,
  output logic [1:0]        mode_o,
  output logic              pd_o
);
  mode_t mode;
  logic  pd_go, frozen, hold;

  mpc_mode_fsm #(.CODE_W(CODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .charger_i(charger_i), .code_i(code_i),
    .wr_mux_i(wr_mux_i), .wr_reg_i(wr_reg_i), .mode_o(mode),
    .pd_go_o(pd_go), .reg_en_o(reg_en_o), .reg_hi_o(reg_hi_o)
  );

  assign frozen = (mode == MODE_DOWN);
  assign hold   = frozen || pd_go;

  mpc_path_decode #(.NCELL(NCELL), .CODE_W(CODE_W)) u_path (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .wr_sel_i(wr_sel_i),
    .code_i(code_i), .open_i(mode != MODE_USUAL),
    .sw_a_o(sw_a_o), .sw_b_o(sw_b_o)
  );

  mpc_balance #(.NCELL(NCELL), .CODE_W(CODE_W)) u_bal (
    .clk(clk), .rst_n(rst_n), .hold_i(frozen), .clear_i(pd_go),
    .wr_bal_i(wr_bal_i), .code_i(code_i), .bal_o(bal_o)
  );

  assign mode_o = mode;
  assign pd_o   = frozen;
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
  parameter int NCELL  = 4,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              charger_i,
  input logic [CODE_W-1:0] code_i,
  input logic              wr_reg_i,
  input logic              wr_bal_i,
  input logic [NCELL:0]    sw_a_o,
  input logic [NCELL:0]    sw_b_o,
  input logic [NCELL-1:0]  bal_o,
  input logic              reg_en_o,
  input logic              reg_hi_o,
  input logic [1:0]        mode_o,
  input logic              pd_o
);
  logic pd_cmd;
  assign pd_cmd = wr_reg_i && (code_i == CODE_W'(3'b100));

  assert_down_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> (sw_a_o == '0 && sw_b_o == '0 && bal_o == '0 && !reg_en_o && mode_o == 2'b10));

  assert_pd_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_cmd && !charger_i && !pd_o) |=> pd_o);

  assert_pd_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_cmd && charger_i && !pd_o) |=> !pd_o);

  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && charger_i) |=> (!pd_o && reg_en_o && !reg_hi_o && mode_o == 2'b01));

  assert_save_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00) |-> (sw_a_o == '0 && sw_b_o == '0));

  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_a_o) <= 1) && ($countones(sw_a_o) == $countones(sw_b_o)));

  assert_usual_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> ($countones(sw_a_o) == 1));

  assert_bal_accum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bal_i && code_i != '0 && !pd_o && !(pd_cmd && !charger_i))
      |=> ((bal_o & $past(bal_o)) == $past(bal_o)));

  assert_hi_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hi_o |-> reg_en_o);
endmodule

bind meas_power_ctrl mpc_checker #(.NCELL(NCELL), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .charger_i(charger_i), .code_i(code_i),
  .wr_reg_i(wr_reg_i), .wr_bal_i(wr_bal_i), .sw_a_o(sw_a_o), .sw_b_o(sw_b_o),
  .bal_o(bal_o), .reg_en_o(reg_en_o), .reg_hi_o(reg_hi_o), .mode_o(mode_o),
  .pd_o(pd_o)
);

// File: tb/meas_power_ctrl_tb.sv
`timescale 1ns/1ps
module meas_power_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic charger = 1'b0;
  logic [2:0] code = '0;
  logic wsel = 0, wmux = 0, wreg = 0, wbal = 0;
  logic [4:0] sw_a, sw_b;
  logic [3:0] bal;
  logic reg_en, reg_hi, pd;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [2:0] m_sel;
  int         m_mode;   // 0 usual, 1 save, 2 down
  logic       m_en, m_hi;
  logic [3:0] m_bal;

  always #2.5 clk = ~clk;

  meas_power_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .charger_i(charger), .code_i(code),
    .wr_sel_i(wsel), .wr_mux_i(wmux), .wr_reg_i(wreg), .wr_bal_i(wbal),
    .sw_a_o(sw_a), .sw_b_o(sw_b), .bal_o(bal), .reg_en_o(reg_en),
    .reg_hi_o(reg_hi), .mode_o(mode), .pd_o(pd)
  );

  function automatic logic [9:0] exp_taps(input logic [2:0] s, input int md);
    logic [4:0] a, b;
    case (s)
      3'd0: begin a = 5'b00010; b = 5'b00100; end
      3'd1: begin a = 5'b00100; b = 5'b01000; end
      3'd2: begin a = 5'b01000; b = 5'b10000; end
      3'd3: begin a = 5'b10000; b = 5'b00001; end
      3'd4: begin a = 5'b00100; b = 5'b00100; end
      3'd5: begin a = 5'b01000; b = 5'b01000; end
      3'd6: begin a = 5'b10000; b = 5'b10000; end
      default: begin a = 5'b00001; b = 5'b00001; end
    endcase
    if (md != 0) begin a = '0; b = '0; end
    return {a, b};
  endfunction

  task automatic model_step();
    if (m_mode == 2) begin
      if (charger) begin m_mode = 1; m_en = 1; m_hi = 0; end
    end else if (wreg && code == 3'd4 && !charger) begin
      m_mode = 2; m_en = 0; m_hi = 0; m_bal = '0;
    end else begin
      if (wsel) m_sel = code;
      if (wmux) begin
        if (code == 3'd1) m_mode = 0;
        else if (code == 3'd0 || code == 3'd2 || code == 3'd3) m_mode = 1;
      end
      if (wreg) begin
        if (code == 3'd0 || code == 3'd3) begin m_en = 1; m_hi = 0; end
        else if (code == 3'd1) begin m_en = 0; m_hi = 0; end
        else if (code == 3'd2) begin m_en = 1; m_hi = 1; end
      end
      if (wbal) begin
        if (code == 3'd0) m_bal = '0;
        else m_bal[(int'(code) - 1) % 4] = 1'b1;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [9:0] t;
    logic [15:0] act, expv;
    t = exp_taps(m_sel, m_mode);
    act  = {sw_a, sw_b, bal, reg_en, reg_hi};
    expv = {t, m_bal, m_en, m_hi};
    checks++;
    if (act !== expv || mode !== 2'(m_mode) || pd !== (m_mode == 2)) begin
      errors++;
      $display("FAIL %s: a/b/bal/en/hi=%b mode=%0d pd=%b expected %b mode=%0d pd=%b",
               tag, act, mode, pd, expv, m_mode, (m_mode == 2));
    end
  endtask

  task automatic step(input logic [2:0] c, input logic s, input logic m,
                      input logic r, input logic b, input logic chg);
    code = c; wsel = s; wmux = m; wreg = r; wbal = b; charger = chg;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wsel = 0; wmux = 0; wreg = 0; wbal = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    m_sel = '0; m_mode = 1; m_en = 1; m_hi = 0; m_bal = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset state");

    // R2: every selection in usual mode
    step(3'd1, 0, 1, 0, 0, 0);
    for (int s = 0; s < 8; s++) begin
      step(3'(s), 1, 0, 0, 0, 0);
      compare("R2 tap pair");
    end

    // R3/R4: grounding then re-running
    step(3'd2, 0, 1, 0, 0, 0); compare("R3 ground code 010");
    step(3'd5, 1, 0, 0, 0, 0); compare("R4 select in save keeps open");
    step(3'd1, 0, 1, 0, 0, 0); compare("R4 run applies stored select");
    step(3'd3, 0, 1, 0, 0, 0); compare("R3 ground code 011");
    step(3'd1, 0, 1, 0, 0, 0);

    // R10: unused codes
    step(3'd6, 0, 1, 0, 0, 0); compare("R10 mux unused");
    step(3'd2, 0, 0, 1, 0, 0); compare("R5 reg high");
    step(3'd7, 0, 0, 1, 0, 0); compare("R10 reg unused");
    step(3'd1, 0, 0, 1, 0, 0); compare("R5 reg off");
    step(3'd3, 0, 0, 1, 0, 0); compare("R5 reg low alt");

    // R9: balancing accumulates
    step(3'd1, 0, 0, 0, 1, 0); step(3'd3, 0, 0, 0, 1, 0);
    compare("R9 bal 1 and 3");
    step(3'd6, 0, 0, 0, 1, 0); compare("R9 code 6 adds cell 2");
    step(3'd4, 0, 0, 0, 1, 0); compare("R9 code 4 adds cell 4");
    step(3'd0, 0, 0, 0, 1, 0); compare("R9 clear");
    step(3'd5, 0, 0, 0, 1, 0);

    // R7: refused with charger
    step(3'd4, 0, 0, 1, 0, 1); compare("R7 pd refused");

    // R6/R8: enter, ignore writes, resume
    step(3'd4, 0, 0, 1, 0, 0); compare("R6 pd entered");
    step(3'd1, 0, 1, 0, 1, 0); compare("R6 writes ignored in down");
    step(3'd2, 0, 0, 1, 0, 0); compare("R6 reg write ignored in down");
    step(3'd0, 0, 0, 0, 0, 1); compare("R8 resume");
    charger = 0;

    // R11: pd wins over simultaneous writes
    step(3'd1, 0, 1, 0, 0, 0); step(3'd2, 0, 0, 0, 1, 0);
    step(3'd4, 1, 1, 1, 1, 0); compare("R11 pd wins");
    step(3'd0, 0, 0, 0, 0, 1); compare("R8 resume after R11");
    charger = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] st;
      logic chg;
      st  = 4'($urandom_range(0, 15));
      chg = ($urandom_range(0, 9) == 0);
      step(3'($urandom_range(0, 7)), st[0], st[1], st[2] & ($urandom_range(0, 3) == 0), st[3], chg);
      compare("RAND R2 R3 R5 R6 R9");
    end
    finish_run();
  end
endmodule